// File: doc/BRIEF.md
# MESI Snoop Response Controller

This block answers snoop transactions that other bus masters place on a shared processor bus, on behalf of a small direct-mapped data cache whose lines carry MESI states. Each snoop brings a transaction type code, a global qualifier and an address. The block looks up the addressed line in its tag/state array. It then drives a one-cycle retry and shared response, moves the line to its new state, and starts a copy-back or push-out of modified data when one is needed. It also holds a single load-reserve address and drops that reservation when a write snoop lands on the reserved line.

The cache's own allocation path writes the array through a fill port. The processor sets the reservation through a reserve port and reads `resv_valid` back. A side probe port returns the MESI state of any address. A write-back engine outside the block serves push requests and acknowledges each one. The line's final state is written only on that acknowledge.

The controller is built around a three-state machine:
- `FSM_IDLE` accepts snoops.
- A clean-block hit on a Modified line moves it to `FSM_COPY` (copy-back, line ends Exclusive).
- A flush-style hit on a Modified line moves it to `FSM_EVICT` (push-out, line ends Invalid).
- Both wait states return to `FSM_IDLE` on `push_ack`.
- Any snoop that arrives outside `FSM_IDLE`, or while `snp_busy` is high, is answered with retry only.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset, every line reads Invalid, `resv_valid` is 0, and `snp_retry`, `snp_shared` and `push_req` are 0. State encoding on `fill_state`/`probe_state`: I=0, S=1, E=2, M=3.
- R2: A snoop with `snp_global` low has no effect: no response and no state change.
- R3: Clean block (`snp_tt[3:1]`=000) leaves I, S and E lines unchanged. On an M line it raises `push_req` with `push_flush`=0 and no retry. The line stays M until `push_ack` and then becomes E.
- R4: Flush block (`snp_tt[3:1]`=001) moves an S or E line to I with no response.
- R5: Flush block on an M line pulses `snp_retry` and `snp_shared` together for one cycle and raises `push_req` with `push_flush`=1. The line becomes I on `push_ack`.
- R6: Write-with-flush (`snp_tt[3:1]`=010) behaves like flush block. `snp_tt[0]` (atomic) changes nothing for any code.
- R7: An accepted write-with-flush whose address line (`snp_addr[31:5]`) equals the reserved line clears `resv_valid`, whether or not the cache holds that line. Other codes and other lines leave the reservation alone.
- R8: Kill block (`snp_tt[3:1]`=011) forces a hit line to I from any state, with no push and no response.
- R9: A qualified snoop that arrives while `snp_busy` is high or a push is pending is answered with `snp_retry`=1 and `snp_shared`=0 the next cycle, and changes no line.
- R10: A snoop whose tag (`snp_addr[31:9]`) differs from the stored tag, or whose line is I, gives no response and no change. The index is `snp_addr[8:5]`.
- R11: `push_req`, `push_idx` and `push_flush` hold steady until `push_ack`. `push_req` drops the cycle after the acknowledge.
- R12: Type codes 100 to 111 in `snp_tt[3:1]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snoop present this cycle |
| snp_global | input | 1 | Global qualifier; snoop acts only when high |
| snp_tt | input | 4 | Type code: [3:1] operation, [0] atomic |
| snp_addr | input | 32 | Snoop address |
| snp_busy | input | 1 | Internal conflict; forces retry |
| snp_retry | output | 1 | Retry response, cycle after the snoop |
| snp_shared | output | 1 | Shared response, cycle after the snoop |
| push_req | output | 1 | Modified-line write-back requested |
| push_idx | output | 4 | Line index to write back |
| push_flush | output | 1 | 1: push-out, line ends I; 0: copy-back, line ends E |
| push_ack | input | 1 | Write-back done; commits the line state |
| fill_valid | input | 1 | Allocate a line |
| fill_addr | input | 32 | Address of the allocated line |
| fill_state | input | 2 | MESI state written on fill |
| resv_set | input | 1 | Set the reservation |
| resv_addr | input | 32 | Reserved address |
| resv_valid | output | 1 | Reservation still held |
| probe_addr | input | 32 | Address to look up |
| probe_state | output | 2 | State of the probed line, I on a tag miss |

## Verification
The hardest case to reach is a snoop that arrives while a push is still pending. The port-level busy input is low at that moment, so only the controller's own wait state can force the retry. The bench reaches it by filling a Modified line and sending a clean block to it. It holds back `push_ack` and snoops a second, valid line, then checks that the retry appears and that the second line is untouched. Only after that does it release the acknowledge. The reservation clear is reached by reserving a line that is not in the cache, so the hit logic cannot be mistaken for the reservation match.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'd0,
        MESI_S = 2'd1,
        MESI_E = 2'd2,
        MESI_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_COPY  = 2'd1,
        FSM_EVICT = 2'd2
    } fsm_t;

    localparam int TT_W = 4;

    localparam logic [2:0] OPC_CLEAN  = 3'd0;
    localparam logic [2:0] OPC_FLUSH  = 3'd1;
    localparam logic [2:0] OPC_WFLUSH = 3'd2;
    localparam logic [2:0] OPC_KILL   = 3'd3;

endpackage

// File: rtl/snoop_tag_array.sv
module snoop_tag_array
    import mesi_snoop_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_a,
    output logic [TAG_W-1:0] rd_tag_a,
    output mesi_t            rd_state_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [TAG_W-1:0] rd_tag_b,
    output mesi_t            rd_state_b,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  mesi_t            upd_state,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  mesi_t            fill_state
);
    localparam int DEPTH = 1 << IDX_W;

    logic [TAG_W-1:0] tag_w   [DEPTH];
    mesi_t            state_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        mesi_t            st_q;
        logic             upd_hit;
        logic             fill_hit;

        assign upd_hit  = upd_en  && (upd_idx  == IDX_W'(g));
        assign fill_hit = fill_en && (fill_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                st_q  <= MESI_I;
            end else if (upd_hit) begin
                st_q <= upd_state;
            end else if (fill_hit) begin
                st_q  <= fill_state;
                tag_q <= fill_tag;
            end
        end

        assign tag_w[g]   = tag_q;
        assign state_w[g] = st_q;
    end

    assign rd_tag_a   = tag_w[rd_idx_a];
    assign rd_state_a = state_w[rd_idx_a];
    assign rd_tag_b   = tag_w[rd_idx_b];
    assign rd_state_b = state_w[rd_idx_b];

endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
    import mesi_snoop_pkg::*;
(
    input  logic [2:0] op,
    input  logic       hit,
    input  mesi_t      line_state,
    output logic       upd_en,
    output mesi_t      upd_state,
    output logic       go_copy,
    output logic       go_evict,
    output logic       rsp_retry,
    output logic       rsp_shared,
    output logic       is_wflush
);
    always_comb begin
        upd_en     = 1'b0;
        upd_state  = MESI_I;
        go_copy    = 1'b0;
        go_evict   = 1'b0;
        rsp_retry  = 1'b0;
        rsp_shared = 1'b0;
        is_wflush  = 1'b0;
        unique case (op)
            OPC_CLEAN: begin
                if (hit && line_state == MESI_M) begin
                    go_copy = 1'b1;
                end
            end
            OPC_FLUSH, OPC_WFLUSH: begin
                is_wflush = (op == OPC_WFLUSH);
                if (hit) begin
                    if (line_state == MESI_M) begin
                        go_evict   = 1'b1;
                        rsp_retry  = 1'b1;
                        rsp_shared = 1'b1;
                    end else begin
                        upd_en = 1'b1;
                    end
                end
            end
            OPC_KILL: begin
                upd_en = hit;
            end
            default: begin
                upd_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/snoop_resv.sv
module snoop_resv #(
    parameter int LINE_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set,
    input  logic [LINE_W-1:0] set_line,
    input  logic              wr_chk,
    input  logic [LINE_W-1:0] wr_line,
    output logic              valid,
    output logic [LINE_W-1:0] line
);
    logic              valid_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            line_q  <= '0;
        end else if (set) begin
            valid_q <= 1'b1;
            line_q  <= set_line;
        end else if (wr_chk && valid_q && wr_line == line_q) begin
            valid_q <= 1'b0;
        end
    end

    assign valid = valid_q;
    assign line  = line_q;

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_snoop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  logic              snp_global,
    input  logic [TT_W-1:0]   snp_tt,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_busy,
    output logic              snp_retry,
    output logic              snp_shared,
    output logic              push_req,
    output logic [IDX_W-1:0]  push_idx,
    output logic              push_flush,
    input  logic              push_ack,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [1:0]        fill_state,
    input  logic              resv_set,
    input  logic [ADDR_W-1:0] resv_addr,
    output logic              resv_valid,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic [1:0]        probe_state
);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = ADDR_W - OFF_W;

    fsm_t             fsm_q, fsm_d;
    logic [IDX_W-1:0] pend_idx_q;
    logic             retry_q, shared_q;

    logic [IDX_W-1:0] snp_idx;
    logic [TAG_W-1:0] snp_tag;
    logic [TAG_W-1:0] a_tag, b_tag;
    mesi_t            a_state, b_state;
    logic             qual, busy_int, accept, hit;

    logic             dec_upd, dec_copy, dec_evict, dec_retry, dec_shared, dec_wflush;
    mesi_t            dec_state;

    logic             arr_upd_en;
    logic [IDX_W-1:0] arr_upd_idx;
    mesi_t            arr_upd_state;
    logic [LINE_W-1:0] resv_line_q;

    assign snp_idx  = snp_addr[OFF_W +: IDX_W];
    assign snp_tag  = snp_addr[ADDR_W-1 -: TAG_W];
    assign qual     = snp_valid && snp_global;
    assign busy_int = snp_busy || (fsm_q != FSM_IDLE);
    assign accept   = qual && !busy_int;
    assign hit      = (a_tag == snp_tag) && (a_state != MESI_I);

    snoop_tag_array #(
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx_a   (snp_idx),
        .rd_tag_a   (a_tag),
        .rd_state_a (a_state),
        .rd_idx_b   (probe_addr[OFF_W +: IDX_W]),
        .rd_tag_b   (b_tag),
        .rd_state_b (b_state),
        .upd_en     (arr_upd_en),
        .upd_idx    (arr_upd_idx),
        .upd_state  (arr_upd_state),
        .fill_en    (fill_valid),
        .fill_idx   (fill_addr[OFF_W +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_state (mesi_t'(fill_state))
    );

    snoop_decide u_decide (
        .op         (snp_tt[TT_W-1:1]),
        .hit        (hit),
        .line_state (a_state),
        .upd_en     (dec_upd),
        .upd_state  (dec_state),
        .go_copy    (dec_copy),
        .go_evict   (dec_evict),
        .rsp_retry  (dec_retry),
        .rsp_shared (dec_shared),
        .is_wflush  (dec_wflush)
    );

    snoop_resv #(
        .LINE_W (LINE_W)
    ) u_resv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (resv_set),
        .set_line (resv_addr[ADDR_W-1:OFF_W]),
        .wr_chk   (accept && dec_wflush),
        .wr_line  (snp_addr[ADDR_W-1:OFF_W]),
        .valid    (resv_valid),
        .line     (resv_line_q)
    );

    // Next-state logic
    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q)
            FSM_IDLE: begin
                if (accept && dec_copy) begin
                    fsm_d = FSM_COPY;
                end else if (accept && dec_evict) begin
                    fsm_d = FSM_EVICT;
                end
            end
            FSM_COPY, FSM_EVICT: begin
                if (push_ack) begin
                    fsm_d = FSM_IDLE;
                end
            end
            default: fsm_d = FSM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q      <= FSM_IDLE;
            pend_idx_q <= '0;
        end else begin
            fsm_q <= fsm_d;
            if (fsm_q == FSM_IDLE && fsm_d != FSM_IDLE) begin
                pend_idx_q <= snp_idx;
            end
        end
    end

    // Array write: immediate snoop update in idle, commit on acknowledge
    always_comb begin
        arr_upd_en    = 1'b0;
        arr_upd_idx   = snp_idx;
        arr_upd_state = dec_state;
        unique case (fsm_q)
            FSM_IDLE: begin
                arr_upd_en = accept && dec_upd;
            end
            FSM_COPY: begin
                arr_upd_en    = push_ack;
                arr_upd_idx   = pend_idx_q;
                arr_upd_state = MESI_E;
            end
            FSM_EVICT: begin
                arr_upd_en    = push_ack;
                arr_upd_idx   = pend_idx_q;
                arr_upd_state = MESI_I;
            end
            default: arr_upd_en = 1'b0;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_q  <= 1'b0;
            shared_q <= 1'b0;
        end else begin
            retry_q  <= qual && (busy_int || dec_retry);
            shared_q <= accept && dec_shared;
        end
    end

    assign snp_retry   = retry_q;
    assign snp_shared  = shared_q;
    assign push_req    = (fsm_q != FSM_IDLE);
    assign push_flush  = (fsm_q == FSM_EVICT);
    assign push_idx    = pend_idx_q;
    assign probe_state = (b_tag == probe_addr[ADDR_W-1 -: TAG_W]) ? b_state : MESI_I;

endmodule

// File: rtl/mesi_snoop_chk.sv
module mesi_snoop_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    snp_valid,
    input logic                    snp_global,
    input logic [3:0]              snp_tt,
    input logic [ADDR_W-1:0]       snp_addr,
    input logic                    snp_busy,
    input logic                    snp_retry,
    input logic                    snp_shared,
    input logic                    push_req,
    input logic [IDX_W-1:0]        push_idx,
    input logic                    push_flush,
    input logic                    push_ack,
    input logic                    resv_set,
    input logic                    resv_valid,
    input logic [ADDR_W-OFF_W-1:0] resv_line
);
    AST_NO_GLOBAL_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && snp_global) |=> !snp_retry && !snp_shared); // R2

    AST_SHARED_NEEDS_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> snp_retry); // R5

    AST_EVICT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_req) && push_flush |-> snp_retry && snp_shared); // R5

    AST_COPY_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push_req) && !push_flush |-> !snp_retry); // R3

    AST_BUSY_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_global && (snp_busy || push_req) |=> snp_retry && !snp_shared); // R9

    AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && !push_ack |=> push_req && $stable(push_idx) && $stable(push_flush)); // R11

    AST_PUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && push_ack |=> !push_req); // R11

    AST_RESV_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        resv_valid && snp_valid && snp_global && !snp_busy && !push_req && !resv_set
        && snp_tt[3:1] == 3'd2 && snp_addr[ADDR_W-1:OFF_W] == resv_line |=> !resv_valid); // R7

endmodule

bind mesi_snoop_ctrl mesi_snoop_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_valid  (snp_valid),
    .snp_global (snp_global),
    .snp_tt     (snp_tt),
    .snp_addr   (snp_addr),
    .snp_busy   (snp_busy),
    .snp_retry  (snp_retry),
    .snp_shared (snp_shared),
    .push_req   (push_req),
    .push_idx   (push_idx),
    .push_flush (push_flush),
    .push_ack   (push_ack),
    .resv_set   (resv_set),
    .resv_valid (resv_valid),
    .resv_line  (resv_line_q)
);

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;

    localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;
    localparam logic [3:0] T_CLEAN = 4'b0000, T_FLUSH = 4'b0010, T_WF = 4'b0100,
                           T_WFA = 4'b0101, T_KILL = 4'b0110;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 1'b0, snp_global = 1'b0, snp_busy = 1'b0;
    logic [3:0]  snp_tt = '0;
    logic [31:0] snp_addr = '0;
    logic        snp_retry, snp_shared, push_req, push_flush, resv_valid;
    logic [3:0]  push_idx;
    logic        push_ack = 1'b0, fill_valid = 1'b0, resv_set = 1'b0;
    logic [31:0] fill_addr = '0, resv_addr = '0, probe_addr = '0;
    logic [1:0]  fill_state = '0;
    logic [1:0]  probe_state;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    mesi_snoop_ctrl uut (
        .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_global(snp_global),
        .snp_tt(snp_tt), .snp_addr(snp_addr), .snp_busy(snp_busy),
        .snp_retry(snp_retry), .snp_shared(snp_shared), .push_req(push_req),
        .push_idx(push_idx), .push_flush(push_flush), .push_ack(push_ack),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_state(fill_state),
        .resv_set(resv_set), .resv_addr(resv_addr), .resv_valid(resv_valid),
        .probe_addr(probe_addr), .probe_state(probe_state)
    );

    function automatic logic [31:0] mk(input int tag, input int idx, input int off);
        return (32'(tag) << 9) | (32'(idx) << 5) | 32'(off);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic fill(input logic [31:0] a, input logic [1:0] st);
        fill_valid = 1'b1; fill_addr = a; fill_state = st;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic snoop(input logic [3:0] tt, input logic glob, input logic [31:0] a);
        snp_valid = 1'b1; snp_global = glob; snp_tt = tt; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0; snp_global = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, output logic [1:0] st);
        probe_addr = a;
        #1;
        st = probe_state;
    endtask

    task automatic ack();
        push_ack = 1'b1;
        @(negedge clk);
        push_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [1:0] st;
        check("R1 retry", 32'(snp_retry), 0);
        check("R1 shared", 32'(snp_shared), 0);
        check("R1 push_req", 32'(push_req), 0);
        check("R1 resv_valid", 32'(resv_valid), 0);
        for (int i = 0; i < 16; i++) begin
            probe(mk(0, i, 0), st);
            check("R1 line invalid", 32'(st), 32'(SI));
        end
    endtask

    task automatic t_global();
        logic [1:0] st;
        fill(mk(1, 1, 0), SM);
        snoop(T_FLUSH, 1'b0, mk(1, 1, 0));
        check("R2 retry", 32'(snp_retry), 0);
        check("R2 push_req", 32'(push_req), 0);
        snoop(T_KILL, 1'b0, mk(1, 1, 0));
        probe(mk(1, 1, 0), st);
        check("R2 state kept", 32'(st), 32'(SM));
    endtask

    task automatic t_clean();
        logic [1:0] st;
        fill(mk(3, 2, 0), SS);
        fill(mk(3, 3, 0), SE);
        snoop(T_CLEAN, 1'b1, mk(3, 2, 4));
        check("R3 S no retry", 32'(snp_retry), 0);
        probe(mk(3, 2, 0), st);
        check("R3 S kept", 32'(st), 32'(SS));
        snoop(T_CLEAN, 1'b1, mk(3, 3, 0));
        probe(mk(3, 3, 0), st);
        check("R3 E kept", 32'(st), 32'(SE));
        check("R3 no push", 32'(push_req), 0);
        fill(mk(3, 4, 0), SM);
        snoop(T_CLEAN, 1'b1, mk(3, 4, 8));
        check("R3 push_req", 32'(push_req), 1);
        check("R3 copy kind", 32'(push_flush), 0);
        check("R3 no retry", 32'(snp_retry), 0);
        check("R3 push_idx", 32'(push_idx), 4);
        repeat (3) @(negedge clk);
        check("R11 req held", 32'(push_req), 1);
        check("R11 idx held", 32'(push_idx), 4);
        probe(mk(3, 4, 0), st);
        check("R11 M until ack", 32'(st), 32'(SM));
        ack();
        check("R11 req dropped", 32'(push_req), 0);
        probe(mk(3, 4, 0), st);
        check("R3 M to E", 32'(st), 32'(SE));
    endtask

    task automatic t_flush();
        logic [1:0] st;
        fill(mk(5, 6, 0), SS);
        fill(mk(5, 7, 0), SE);
        snoop(T_FLUSH, 1'b1, mk(5, 6, 0));
        check("R4 no retry", 32'(snp_retry), 0);
        probe(mk(5, 6, 0), st);
        check("R4 S to I", 32'(st), 32'(SI));
        snoop(T_FLUSH, 1'b1, mk(5, 7, 0));
        probe(mk(5, 7, 0), st);
        check("R4 E to I", 32'(st), 32'(SI));
        fill(mk(5, 8, 0), SM);
        snoop(T_FLUSH, 1'b1, mk(5, 8, 0));
        check("R5 retry", 32'(snp_retry), 1);
        check("R5 shared", 32'(snp_shared), 1);
        check("R5 push kind", 32'(push_flush), 1);
        check("R5 push idx", 32'(push_idx), 8);
        @(negedge clk);
        check("R5 retry one cycle", 32'(snp_retry), 0);
        ack();
        probe(mk(5, 8, 0), st);
        check("R5 M to I", 32'(st), 32'(SI));
    endtask

    task automatic t_wflush();
        logic [1:0] st;
        fill(mk(6, 9, 0), SE);
        snoop(T_WF, 1'b1, mk(6, 9, 0));
        probe(mk(6, 9, 0), st);
        check("R6 plain E to I", 32'(st), 32'(SI));
        fill(mk(6, 10, 0), SM);
        snoop(T_WFA, 1'b1, mk(6, 10, 0));
        check("R6 atomic retry", 32'(snp_retry), 1);
        check("R6 atomic shared", 32'(snp_shared), 1);
        check("R6 atomic push", 32'(push_flush), 1);
        ack();
        probe(mk(6, 10, 0), st);
        check("R6 atomic M to I", 32'(st), 32'(SI));
        fill(mk(6, 11, 0), SM);
        snoop(4'b0001, 1'b1, mk(6, 11, 0));
        check("R6 atomic clean copy", 32'(push_req & ~push_flush), 1);
        ack();
        probe(mk(6, 11, 0), st);
        check("R6 atomic clean to E", 32'(st), 32'(SE));
    endtask

    task automatic t_resv();
        resv_set = 1'b1; resv_addr = mk(40, 12, 3);
        @(negedge clk);
        resv_set = 1'b0;
        check("R7 set", 32'(resv_valid), 1);
        snoop(T_FLUSH, 1'b1, mk(40, 12, 0));
        check("R7 flush keeps", 32'(resv_valid), 1);
        snoop(T_WF, 1'b1, mk(41, 12, 0));
        check("R7 other line keeps", 32'(resv_valid), 1);
        snoop(T_WFA, 1'b1, mk(40, 12, 16));
        check("R7 wflush clears", 32'(resv_valid), 0);
    endtask

    task automatic t_kill();
        logic [1:0] st;
        fill(mk(7, 13, 0), SM);
        snoop(T_KILL, 1'b1, mk(7, 13, 0));
        check("R8 no push", 32'(push_req), 0);
        check("R8 no retry", 32'(snp_retry), 0);
        probe(mk(7, 13, 0), st);
        check("R8 M to I", 32'(st), 32'(SI));
        fill(mk(7, 14, 0), SS);
        snoop(T_KILL, 1'b1, mk(7, 14, 0));
        probe(mk(7, 14, 0), st);
        check("R8 S to I", 32'(st), 32'(SI));
    endtask

    task automatic t_busy();
        logic [1:0] st;
        fill(mk(8, 15, 0), SE);
        snp_busy = 1'b1;
        snoop(T_FLUSH, 1'b1, mk(8, 15, 0));
        snp_busy = 1'b0;
        check("R9 busy retry", 32'(snp_retry), 1);
        check("R9 busy no shared", 32'(snp_shared), 0);
        probe(mk(8, 15, 0), st);
        check("R9 busy state kept", 32'(st), 32'(SE));
        fill(mk(8, 0, 0), SM);
        snoop(T_CLEAN, 1'b1, mk(8, 0, 0));
        snoop(T_KILL, 1'b1, mk(8, 15, 0));
        check("R9 pending retry", 32'(snp_retry), 1);
        probe(mk(8, 15, 0), st);
        check("R9 pending state kept", 32'(st), 32'(SE));
        check("R11 idx unchanged", 32'(push_idx), 0);
        ack();
    endtask

    task automatic t_miss();
        logic [1:0] st;
        fill(mk(9, 5, 0), SM);
        snoop(T_FLUSH, 1'b1, mk(10, 5, 0));
        check("R10 miss no retry", 32'(snp_retry), 0);
        check("R10 miss no push", 32'(push_req), 0);
        probe(mk(9, 5, 0), st);
        check("R10 miss state kept", 32'(st), 32'(SM));
    endtask

    task automatic t_codes();
        logic [1:0] st;
        for (int c = 8; c < 16; c++) begin
            snoop(4'(c), 1'b1, mk(9, 5, 0));
            check("R12 no retry", 32'(snp_retry), 0);
            check("R12 no push", 32'(push_req), 0);
        end
        probe(mk(9, 5, 0), st);
        check("R12 state kept", 32'(st), 32'(SM));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global();
        t_clean();
        t_flush();
        t_wflush();
        t_resv();
        t_kill();
        t_busy();
        t_miss();
        t_codes();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule